// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches the health of a twisted-pair link while the local transmitter has nothing to send. On the transmit side it emits a short single-polarity test pulse at a fixed interval during idle periods and stays silent while transmit is enabled. On the receive side it takes an already-thresholded receive-pulse level and a receive-data-valid flag. It measures the width of each received pulse and accepts only those inside a configured window. A silence timer declares the link failed when neither a valid pulse nor data has arrived for too long.

Link status goes out as a single three-state indicator pin. The block drives it as a value/enable pair. With the enable low the pin floats, which means the link has failed. When the enable is high and the value is low, the block is receiving link pulses but no data. When the value is high, data is arriving, and an attached indicator flickers. Every timing constant is a cycle count of the block clock, nominally 10 MHz.

Top module: `lip_monitor`

## Requirements
- R1: While reset is asserted and immediately after it, `link_oe_o`, `link_val_o` and `tx_lp_o` are all 0 (failed link, pin floating, no pulse).
- R2: With `tx_en_i` low, `tx_lp_o` rises `TX_PERIOD_CYC` clock edges after reset release or after the last edge that sampled `tx_en_i` high. It stays high for exactly `TX_PULSE_CYC` cycles and repeats every `TX_PERIOD_CYC` cycles.
- R3: A clock edge that samples `tx_en_i` high forces `tx_lp_o` low after that edge, including in the middle of a pulse.
- R4: A received pulse on `rx_lp_i` that is high for N consecutive samples, with `RX_MIN_CYC` <= N <= `RX_MAX_CYC` (both bounds inclusive), is valid. In a failed state, `link_oe_o` goes to 1 two edges after the first low sample that ends the pulse.
- R5: A received pulse shorter than `RX_MIN_CYC` or longer than `RX_MAX_CYC` samples is ignored: a failed link stays failed (`link_oe_o` = 0).
- R6: With the link good and `rx_dv_i` low, the pin is driven low (`link_oe_o` = 1, `link_val_o` = 0).
- R7: When the link is good, an edge that samples `rx_dv_i` high makes `link_val_o` 1 after that edge, and an edge that samples it low makes `link_val_o` 0. If the link has failed, `rx_dv_i` restores it on the same edge.
- R8: After the last event (a valid pulse or `rx_dv_i`) is taken in, the link stays good for `FAIL_CYC` - 1 further edges and fails on the `FAIL_CYC`-th.
- R9: Each new event restarts the silence timer from zero.
- R10: `link_val_o` is never 1 while `link_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, nominally 10 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable from the controller; high suppresses test pulses |
| rx_lp_i | input | 1 | Thresholded receive-pulse level from the comparator |
| rx_dv_i | input | 1 | Receive data valid (packet being received) |
| tx_lp_o | output | 1 | Link test pulse request to the driver path |
| link_val_o | output | 1 | Value for the three-state status pin |
| link_oe_o | output | 1 | Output enable for the three-state status pin; 0 means failed link |

## Verification
The bench shrinks the timing so that everything fits in a short run: a pulse period of 40 cycles, a pulse width of 3, a receive window of 2 to 4 samples and a failure timeout of 200 cycles. This brings many complete pulse trains and many fail/restore transitions of the silence timer into reach. It also allows both window bounds to be hit and then missed by one. The bench sets the receive synchronizer depth to 0, so each received sample lands on a known edge. The random phase mixes pulses of width 1 to 6, data bursts, transmit bursts and silences longer than the timeout.

// File: rtl/lip_pkg.sv
package lip_pkg;

   typedef enum logic {
      LINK_DOWN = 1'b0,
      LINK_UP   = 1'b1
   } link_state_e;

   // counter width able to hold values 0..maxval
   function automatic int cnt_w(input longint maxval);
      int w;
      w = 1;
      while ((longint'(1) << w) <= maxval) w++;
      return w;
   endfunction

endpackage

// File: rtl/lip_tx_gen.sv
module lip_tx_gen
   import lip_pkg::*;
#(
   parameter int TX_PERIOD_CYC = 160000,
   parameter int TX_PULSE_CYC  = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tx_en_i,
   output logic tx_lp_o
);

   localparam int PW = cnt_w(TX_PERIOD_CYC);
   localparam int WW = cnt_w(TX_PULSE_CYC);
   localparam logic [PW-1:0] PER_LAST = PW'(TX_PERIOD_CYC - 1);
   localparam logic [WW-1:0] WIDTH    = WW'(TX_PULSE_CYC);

   logic [PW-1:0] idle_q;
   logic [WW-1:0] pls_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idle_q <= '0;
         pls_q  <= '0;
      end else if (tx_en_i) begin
         idle_q <= '0;
         pls_q  <= '0;
      end else if (idle_q == PER_LAST) begin
         idle_q <= '0;
         pls_q  <= WIDTH;
      end else begin
         idle_q <= idle_q + 1'b1;
         if (pls_q != '0) pls_q <= pls_q - 1'b1;
      end
   end

   assign tx_lp_o = (pls_q != '0);

endmodule

// File: rtl/lip_rx_qual.sv
module lip_rx_qual
   import lip_pkg::*;
#(
   parameter int RX_MIN_CYC  = 1,
   parameter int RX_MAX_CYC  = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_lp_i,
   output logic lp_valid_o
);

   localparam int RW = cnt_w(RX_MAX_CYC + 1);
   localparam logic [RW-1:0] R_MIN = RW'(RX_MIN_CYC);
   localparam logic [RW-1:0] R_MAX = RW'(RX_MAX_CYC);
   localparam logic [RW-1:0] R_SAT = RW'(RX_MAX_CYC + 1);

   logic [SYNC_STAGES:0] chain;
   logic                 rx_s;
   logic [RW-1:0]        run_q;
   logic                 valid_q;

   assign chain[0] = rx_lp_i;

   // optional synchronizer; depth 0 passes the comparator level straight through
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain[g+1] <= 1'b0;
         else         chain[g+1] <= chain[g];
      end
   end

   assign rx_s = chain[SYNC_STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= !rx_s && (run_q >= R_MIN) && (run_q <= R_MAX);
         if (!rx_s)              run_q <= '0;
         else if (run_q != R_SAT) run_q <= run_q + 1'b1;
      end
   end

   assign lp_valid_o = valid_q;

endmodule

// File: rtl/lip_watchdog.sv
module lip_watchdog
   import lip_pkg::*;
#(
   parameter int FAIL_CYC = 1000000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic event_i,
   output logic link_up_o
);

   localparam int FW = cnt_w(FAIL_CYC);
   localparam logic [FW-1:0] F_LAST = FW'(FAIL_CYC - 1);

   link_state_e   st_q;
   logic [FW-1:0] sil_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= LINK_DOWN;
         sil_q <= '0;
      end else if (event_i) begin
         st_q  <= LINK_UP;
         sil_q <= '0;
      end else if (st_q == LINK_UP) begin
         if (sil_q == F_LAST) begin
            st_q  <= LINK_DOWN;
            sil_q <= '0;
         end else begin
            sil_q <= sil_q + 1'b1;
         end
      end
   end

   assign link_up_o = (st_q == LINK_UP);

endmodule

// File: rtl/lip_monitor.sv
module lip_monitor
   import lip_pkg::*;
#(
   parameter int TX_PERIOD_CYC = 160000,
   parameter int TX_PULSE_CYC  = 1,
   parameter int RX_MIN_CYC    = 1,
   parameter int RX_MAX_CYC    = 1,
   parameter int FAIL_CYC      = 1000000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tx_en_i,
   input  logic rx_lp_i,
   input  logic rx_dv_i,
   output logic tx_lp_o,
   output logic link_val_o,
   output logic link_oe_o
);

   if (TX_PULSE_CYC < 1 || TX_PULSE_CYC >= TX_PERIOD_CYC) begin : g_bad_tx
      $error("lip_monitor: TX_PULSE_CYC must be in 1..TX_PERIOD_CYC-1");
   end
   if (RX_MIN_CYC < 1 || RX_MAX_CYC < RX_MIN_CYC) begin : g_bad_rx
      $error("lip_monitor: need 1 <= RX_MIN_CYC <= RX_MAX_CYC");
   end
   if (FAIL_CYC < 2) begin : g_bad_fail
      $error("lip_monitor: FAIL_CYC must be at least 2");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("lip_monitor: SYNC_STAGES must not be negative");
   end

   logic lp_valid;
   logic link_up;
   logic dv_q;

   lip_tx_gen #(
      .TX_PERIOD_CYC(TX_PERIOD_CYC),
      .TX_PULSE_CYC (TX_PULSE_CYC)
   ) u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tx_en_i(tx_en_i),
      .tx_lp_o(tx_lp_o)
   );

   lip_rx_qual #(
      .RX_MIN_CYC (RX_MIN_CYC),
      .RX_MAX_CYC (RX_MAX_CYC),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_lp_i   (rx_lp_i),
      .lp_valid_o(lp_valid)
   );

   lip_watchdog #(
      .FAIL_CYC(FAIL_CYC)
   ) u_wd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .event_i  (lp_valid | rx_dv_i),
      .link_up_o(link_up)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dv_q <= 1'b0;
      else         dv_q <= rx_dv_i;
   end

   assign link_oe_o  = link_up;
   assign link_val_o = link_up & dv_q;

endmodule

// File: rtl/lip_monitor_chk.sv
module lip_monitor_chk
   import lip_pkg::*;
#(
   parameter int TX_PULSE_CYC = 1,
   parameter int FAIL_CYC     = 1000000
) (
   input logic clk_i,
   input logic rst_ni,
   input logic tx_en_i,
   input logic rx_dv_i,
   input logic tx_lp_o,
   input logic link_val_o,
   input logic link_oe_o,
   input logic lp_valid_i
);

   localparam int FW = cnt_w(FAIL_CYC);
   localparam int WW = cnt_w(TX_PULSE_CYC);

   logic [FW-1:0] quiet_q;
   logic [WW-1:0] hi_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         quiet_q <= '0;
         hi_q    <= '0;
      end else begin
         if (lp_valid_i || rx_dv_i)          quiet_q <= '0;
         else if (quiet_q != FW'(FAIL_CYC))  quiet_q <= quiet_q + 1'b1;
         if (!tx_lp_o)                       hi_q <= '0;
         else if (hi_q != WW'(TX_PULSE_CYC)) hi_q <= hi_q + 1'b1;
      end
   end

   a_r3_quiet_during_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_en_i |=> !tx_lp_o);

   a_r2_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_lp_o |-> (hi_q < WW'(TX_PULSE_CYC)));

   a_r10_val_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_val_o |-> link_oe_o);

   a_r7_data_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_oe_o && rx_dv_i) |=> link_val_o);

   a_r4_restore_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(link_oe_o) |-> ($past(lp_valid_i) || $past(rx_dv_i)));

   a_r8_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_oe_o |-> (quiet_q < FW'(FAIL_CYC)));

endmodule

bind lip_monitor lip_monitor_chk #(
   .TX_PULSE_CYC(TX_PULSE_CYC),
   .FAIL_CYC    (FAIL_CYC)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tx_en_i   (tx_en_i),
   .rx_dv_i   (rx_dv_i),
   .tx_lp_o   (tx_lp_o),
   .link_val_o(link_val_o),
   .link_oe_o (link_oe_o),
   .lp_valid_i(lp_valid)
);

// File: tb/lip_monitor_bench.sv
`timescale 1ns/1ps
module lip_monitor_bench;

   localparam int P    = 40;
   localparam int W    = 3;
   localparam int RMIN = 2;
   localparam int RMAX = 4;
   localparam int F    = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic rx_lp = 1'b0;
   logic rx_dv = 1'b0;
   logic tx_lp, link_val, link_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit model_on = 1'b0;

   always #2.5 clk = ~clk;

   lip_monitor #(
      .TX_PERIOD_CYC(P),
      .TX_PULSE_CYC (W),
      .RX_MIN_CYC   (RMIN),
      .RX_MAX_CYC   (RMAX),
      .FAIL_CYC     (F),
      .SYNC_STAGES  (0)
   ) u_lip_monitor (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tx_en_i   (tx_en),
      .rx_lp_i   (rx_lp),
      .rx_dv_i   (rx_dv),
      .tx_lp_o   (tx_lp),
      .link_val_o(link_val),
      .link_oe_o (link_oe)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- requirement-level reference model ----------------
   int  m_idle, m_pls, m_run, m_sil;
   bit  m_valid, m_good, m_dvq;

   function automatic bit width_ok(input int n);
      return (n >= RMIN) && (n <= RMAX);
   endfunction

   always @(posedge clk) begin
      bit nv, evt;
      if (!rst_n) begin
         m_idle = 0; m_pls = 0; m_run = 0; m_sil = 0;
         m_valid = 0; m_good = 0; m_dvq = 0;
      end else begin
         if (tx_en) begin m_idle = 0; m_pls = 0; end
         else if (m_idle == P-1) begin m_idle = 0; m_pls = W; end
         else begin m_idle++; if (m_pls > 0) m_pls--; end
         nv    = !rx_lp && width_ok(m_run);
         m_run = rx_lp ? ((m_run > RMAX) ? m_run : m_run + 1) : 0;
         evt   = m_valid || rx_dv;
         if (evt) begin m_good = 1; m_sil = 0; end
         else if (m_good) begin
            if (m_sil == F-1) begin m_good = 0; m_sil = 0; end
            else m_sil++;
         end
         m_dvq   = rx_dv;
         m_valid = nv;
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk(tx_lp,    m_pls != 0,        "R2 model tx_lp");
         chk(link_oe,  m_good,            "R8 model link_oe");
         chk(link_val, m_good && m_dvq,   "R7 model link_val");
      end
   end

   task automatic rx_pulse(input int n);
      for (int i = 0; i < n; i++) begin rx_lp = 1'b1; @(negedge clk); end
      rx_lp = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int first, highs;
      bit at2p;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(negedge clk);
      chk(link_oe, 1'b0, "R1 oe in reset");
      chk(link_val, 1'b0, "R1 val in reset");
      chk(tx_lp, 1'b0, "R1 tx in reset");
      rst_n = 1'b1;
      model_on = 1'b1;

      // R2: first pulse after P edges, width W, repeat at 2P
      first = 0; highs = 0; at2p = 0;
      for (int i = 1; i <= 2*P; i++) begin
         @(negedge clk);
         if (tx_lp && first == 0) first = i;
         if (tx_lp && i < 2*P) highs++;
         if (i == 2*P) at2p = tx_lp;
      end
      chk(first == P, 1'b1, "R2 first pulse position");
      chk(highs == W, 1'b1, "R2 pulse width");
      chk(at2p, 1'b1, "R2 period");
      chk(link_oe, 1'b0, "R1 still failed after reset");

      // R3: enable mid-pulse kills it
      tx_en = 1'b1;
      @(negedge clk);
      chk(tx_lp, 1'b0, "R3 abort pulse");
      highs = 0;
      for (int i = 0; i < 2*P; i++) begin @(negedge clk); if (tx_lp) highs++; end
      chk(highs == 0, 1'b1, "R3 no pulse while enabled");
      tx_en = 1'b0;
      first = 0;
      for (int i = 1; i <= P; i++) begin
         @(negedge clk);
         if (tx_lp && first == 0) first = i;
      end
      chk(first == P, 1'b1, "R2 restart after enable");

      // R5: out-of-window pulses ignored
      rx_pulse(RMIN-1); wait_n(4);
      chk(link_oe, 1'b0, "R5 short pulse ignored");
      rx_pulse(RMAX+1); wait_n(4);
      chk(link_oe, 1'b0, "R5 long pulse ignored");

      // R4: lower bound accepted, two edges after the ending sample
      rx_pulse(RMIN);
      @(negedge clk);
      chk(link_oe, 1'b0, "R4 not yet up");
      @(negedge clk);
      chk(link_oe, 1'b1, "R4 min width restores");
      chk(link_val, 1'b0, "R6 pulses only drive low");

      // R7: data drives high
      rx_dv = 1'b1; @(negedge clk);
      chk(link_val, 1'b1, "R7 data high");
      rx_dv = 1'b0; @(negedge clk);
      chk(link_val, 1'b0, "R7 data ends");
      chk(link_oe, 1'b1, "R6 back to low");

      // R8 with upper-bound pulse (also R4)
      rx_pulse(RMAX);
      wait_n(F+1);
      chk(link_oe, 1'b1, "R8 still up at limit");
      @(negedge clk);
      chk(link_oe, 1'b0, "R8 timeout fails link");
      chk(link_val, 1'b0, "R10 val low when failed");

      // R7 data restores failed link
      rx_dv = 1'b1; @(negedge clk);
      chk(link_oe, 1'b1, "R7 data restores link");
      chk(link_val, 1'b1, "R7 data restores high");
      rx_dv = 1'b0;

      // R9: a later event restarts the timer
      wait_n(F/2 - 1);
      rx_dv = 1'b1; @(negedge clk);
      rx_dv = 1'b0;
      wait_n(F-1);
      chk(link_oe, 1'b1, "R9 restarted timer holds");
      @(negedge clk);
      chk(link_oe, 1'b0, "R9 restarted timer expires");

      // random mix, compared against the model
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(0, 5))
            0: wait_n($urandom_range(1, 60));
            1: begin rx_pulse($urandom_range(1, 6)); wait_n($urandom_range(1, 5)); end
            2: begin rx_dv = 1'b1; wait_n($urandom_range(1, 8)); rx_dv = 1'b0; end
            3: begin tx_en = 1'b1; wait_n($urandom_range(1, 80)); tx_en = 1'b0; end
            4: wait_n(F + $urandom_range(0, 20));
            default: begin tx_en = $urandom_range(0, 1); rx_pulse(RMIN); wait_n(2); end
         endcase
      end
      tx_en = 1'b0;
      wait_n(3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule